// File: doc/BRIEF.md
# Double-Buffered Transmit Endpoint FIFO

This block holds outgoing packet data for one transmit endpoint in two packet buffers that take turns. Software writes bytes one at a time into the buffer currently assigned to it, then pulses a packet-enable trigger. The trigger marks that buffer as ready to send and moves the write target to the other buffer. Software can therefore fill the next packet while the bus side is still sending the previous one.

The bus side sees the oldest committed buffer. It gets the byte at the current read position, the packet length and a last-byte flag. Each read strobe advances the position. The strobe on the last byte releases the buffer and moves on to the next committed one. A commit with no bytes written produces a zero-length packet that is released by a single read strobe. Writes beyond a programmable maximum packet size are dropped and flagged. A clear request empties both buffers. The clear is held off while a packet is part-way through being read out.

Top module: `tx_ep_dbuf`

## Requirements
- R1: After reset `wr_rdy_o`=1, `rd_vld_o`=0, `err_o`=0, both buffers are empty, and the maximum packet size equals the parameter MAX_PKT.
- R2: A write is accepted when the write buffer is not committed and its byte count is below the maximum packet size. Accepted bytes are read out in the order they were written, starting at position 0.
- R3: A write that is not accepted is dropped and leaves the buffer unchanged. `err_o` is high for exactly the cycle after the rejected write.
- R4: When the write buffer is not committed, `pkt_en_i` commits it and moves writing to the other buffer. When both buffers are committed, `wr_rdy_o` is 0 and writes and triggers have no effect, apart from the error flag that writes raise.
- R5: Committed buffers are presented in commit order. `rd_len_o` gives the byte count, and `rd_last_o` is high at position `rd_len_o`-1. `rd_en_i` advances the position and releases the buffer on the last byte.
- R6: A trigger with no bytes written commits a zero-length packet: `rd_vld_o`=1, `rd_len_o`=0, `rd_last_o`=1. One `rd_en_i` releases it.
- R7: `clr_i` empties both buffers and resets both buffer selections. While a packet is part-way through being read (position not 0), the clear waits and is applied in the first cycle at which the position is back at 0.
- R8: `cfg_we_i` loads the maximum packet size from `cfg_mps_i`. Values above MAX_PKT are stored as MAX_PKT.
- R9: A write and a trigger in the same cycle commit the packet with that byte included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the maximum packet size |
| cfg_mps_i | input | CNT_W | New maximum packet size |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | DATA_W | Byte to write |
| pkt_en_i | input | 1 | Commit the current write buffer |
| clr_i | input | 1 | Clear both buffers |
| wr_rdy_o | output | 1 | At least one buffer is not committed |
| err_o | output | 1 | A write was dropped in the previous cycle |
| rd_en_i | input | 1 | Consume the presented byte |
| rd_vld_o | output | 1 | A committed packet is presented |
| rd_data_o | output | DATA_W | Byte at the read position |
| rd_len_o | output | CNT_W | Length of the presented packet |
| rd_last_o | output | 1 | Presented byte is the last one |

## Verification
The reference model is exercised with several stimulus patterns, and each one separates a different class of fault. Short packets committed back to back test whether buffer ping-pong and commit order are kept. Fills that go past a reduced or clamped maximum size test whether the size cap and the error timing are correct. Zero-length commits, and a write issued together with a trigger, expose off-by-one errors in the last-byte and count logic. A clear issued part-way through a readout, with the second buffer also committed, shows whether the clear is deferred and whether it then wipes both buffers. A long random mix of all inputs catches faults in how these cases interact.

// File: rtl/tx_ep_pkg.sv
package tx_ep_pkg;
  parameter int unsigned TX_DATA_W  = 8;
  parameter int unsigned TX_MAX_PKT = 64;
endpackage

// File: rtl/tx_ep_buf.sv
module tx_ep_buf #(
  parameter int DATA_W = 8,
  parameter int MAX_PKT = 64,
  localparam int CNT_W = $clog2(MAX_PKT + 1),
  localparam int PTR_W = $clog2(MAX_PKT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              release_i,
  input  logic              clear_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem [MAX_PKT];

  always_ff @(posedge clk_i) begin
    if (wr_i && !clear_i) mem[cnt_o[PTR_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      full_o <= 1'b0;
    end else if (clear_i) begin
      cnt_o  <= '0;
      full_o <= 1'b0;
    end else begin
      if (wr_i)     cnt_o  <= cnt_o + 1'b1;
      if (commit_i) full_o <= 1'b1;
      if (release_i) begin
        full_o <= 1'b0;
        cnt_o  <= '0;
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/tx_ep_ctrl.sv
module tx_ep_ctrl #(
  parameter int MAX_PKT = 64,
  localparam int CNT_W = $clog2(MAX_PKT + 1),
  localparam int PTR_W = $clog2(MAX_PKT)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CNT_W-1:0]      cfg_mps_i,
  input  logic                  wr_en_i,
  input  logic                  pkt_en_i,
  input  logic                  clr_i,
  input  logic                  rd_en_i,
  input  logic [1:0][CNT_W-1:0] cnt_i,
  input  logic [1:0]            full_i,
  output logic [1:0]            buf_wr_o,
  output logic [1:0]            buf_commit_o,
  output logic [1:0]            buf_rel_o,
  output logic                  clear_o,
  output logic                  rd_sel_o,
  output logic [PTR_W-1:0]      rd_ptr_o,
  output logic                  clr_pend_o,
  output logic                  wr_rdy_o,
  output logic                  err_o,
  output logic                  rd_vld_o,
  output logic [CNT_W-1:0]      rd_len_o,
  output logic                  rd_last_o
);
  localparam logic [CNT_W-1:0] MPS_MAX = CNT_W'(MAX_PKT);

  logic             wr_sel_q;
  logic [CNT_W-1:0] mps_q;
  logic             wr_acc, pkt_acc, rd_acc, busy;

  assign wr_acc  = wr_en_i && !full_i[wr_sel_q] && (cnt_i[wr_sel_q] < mps_q);
  assign pkt_acc = pkt_en_i && !full_i[wr_sel_q];

  assign rd_vld_o  = full_i[rd_sel_o];
  assign rd_len_o  = cnt_i[rd_sel_o];
  assign rd_last_o = rd_vld_o && ((rd_len_o == '0) || (CNT_W'(rd_ptr_o) + 1'b1 == rd_len_o));
  assign rd_acc    = rd_en_i && rd_vld_o;
  assign wr_rdy_o  = !(&full_i);

  // clear is deferred while a packet is mid-readout
  assign busy    = (rd_ptr_o != '0);
  assign clear_o = (clr_i || clr_pend_o) && !busy;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      buf_wr_o[i]     = wr_acc  && (wr_sel_q == 1'(i));
      buf_commit_o[i] = pkt_acc && (wr_sel_q == 1'(i));
      buf_rel_o[i]    = rd_acc && rd_last_o && (rd_sel_o == 1'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_sel_q   <= 1'b0;
      rd_sel_o   <= 1'b0;
      rd_ptr_o   <= '0;
      clr_pend_o <= 1'b0;
      err_o      <= 1'b0;
      mps_q      <= MPS_MAX;
    end else begin
      err_o      <= wr_en_i && !wr_acc;
      clr_pend_o <= (clr_i || clr_pend_o) && busy;
      if (cfg_we_i) mps_q <= (cfg_mps_i > MPS_MAX) ? MPS_MAX : cfg_mps_i;
      if (clear_o) begin
        wr_sel_q <= 1'b0;
        rd_sel_o <= 1'b0;
        rd_ptr_o <= '0;
      end else begin
        if (pkt_acc) wr_sel_q <= !wr_sel_q;
        if (rd_acc) begin
          if (rd_last_o) begin
            rd_sel_o <= !rd_sel_o;
            rd_ptr_o <= '0;
          end else begin
            rd_ptr_o <= rd_ptr_o + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tx_ep_dbuf.sv
module tx_ep_dbuf
  import tx_ep_pkg::*;
#(
  parameter int DATA_W = TX_DATA_W,
  parameter int MAX_PKT = TX_MAX_PKT,
  localparam int CNT_W = $clog2(MAX_PKT + 1),
  localparam int PTR_W = $clog2(MAX_PKT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_mps_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pkt_en_i,
  input  logic              clr_i,
  output logic              wr_rdy_o,
  output logic              err_o,
  input  logic              rd_en_i,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  rd_len_o,
  output logic              rd_last_o
);
  logic [1:0][CNT_W-1:0]  buf_cnt;
  logic [1:0][DATA_W-1:0] buf_data;
  logic [1:0]             buf_full, buf_wr, buf_commit, buf_rel;
  logic                   buf_clear, rd_sel, clr_pend;
  logic [PTR_W-1:0]       rd_ptr;

  tx_ep_ctrl #(.MAX_PKT(MAX_PKT)) u_ctrl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_mps_i, .wr_en_i, .pkt_en_i, .clr_i, .rd_en_i,
    .cnt_i(buf_cnt), .full_i(buf_full),
    .buf_wr_o(buf_wr), .buf_commit_o(buf_commit), .buf_rel_o(buf_rel),
    .clear_o(buf_clear), .rd_sel_o(rd_sel), .rd_ptr_o(rd_ptr), .clr_pend_o(clr_pend),
    .wr_rdy_o, .err_o, .rd_vld_o, .rd_len_o, .rd_last_o
  );

  for (genvar g = 0; g < 2; g++) begin : g_buf
    tx_ep_buf #(.DATA_W(DATA_W), .MAX_PKT(MAX_PKT)) u_buf (
      .clk_i, .rst_ni,
      .wr_i(buf_wr[g]), .wr_data_i, .commit_i(buf_commit[g]),
      .release_i(buf_rel[g]), .clear_i(buf_clear), .rd_addr_i(rd_ptr),
      .rd_data_o(buf_data[g]), .cnt_o(buf_cnt[g]), .full_o(buf_full[g])
    );
  end

  assign rd_data_o = buf_data[rd_sel];
endmodule

// File: rtl/tx_ep_dbuf_chk.sv
module tx_ep_dbuf_chk #(
  parameter int MAX_PKT = 64,
  localparam int CNT_W = $clog2(MAX_PKT + 1),
  localparam int PTR_W = $clog2(MAX_PKT)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic                  clr_i,
  input logic                  rd_en_i,
  input logic                  wr_rdy_o,
  input logic                  err_o,
  input logic                  rd_vld_o,
  input logic [CNT_W-1:0]      rd_len_o,
  input logic                  rd_last_o,
  input logic [1:0][CNT_W-1:0] buf_cnt,
  input logic [PTR_W-1:0]      rd_ptr,
  input logic                  clr_pend
);
  AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_cnt[0] <= CNT_W'(MAX_PKT)) && (buf_cnt[1] <= CNT_W'(MAX_PKT))); // R2
  AST_DROP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_rdy_o |=> err_o); // R3
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_rdy_o && !rd_en_i && !clr_i && !clr_pend |=> !wr_rdy_o); // R4
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o && (rd_len_o != '0) |-> (CNT_W'(rd_ptr) < rd_len_o)); // R5
  AST_LEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o && !rd_en_i && !clr_i && !clr_pend |=> rd_vld_o && $stable(rd_len_o)); // R5
  AST_ZLP_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o && (rd_len_o == '0) |-> rd_last_o); // R6
  AST_CLR_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ptr != '0) && !rd_en_i |=> rd_vld_o && $stable(rd_ptr)); // R7
endmodule

bind tx_ep_dbuf tx_ep_dbuf_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .clr_i, .rd_en_i, .wr_rdy_o, .err_o,
  .rd_vld_o, .rd_len_o, .rd_last_o,
  .buf_cnt(buf_cnt), .rd_ptr(rd_ptr), .clr_pend(clr_pend)
);

// File: tb/tx_ep_dbuf_tb.sv
module tx_ep_dbuf_tb;
  localparam int DW = 8;
  localparam int MP = 64;
  localparam int CW = $clog2(MP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, wr_en = 0, pkt_en = 0, clr = 0, rd_en = 0;
  logic [CW-1:0] cfg_mps = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_rdy, err, rd_vld, rd_last;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] rd_len;

  always #10 clk = ~clk;

  tx_ep_dbuf #(.DATA_W(DW), .MAX_PKT(MP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mps_i(cfg_mps),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .pkt_en_i(pkt_en), .clr_i(clr),
    .wr_rdy_o(wr_rdy), .err_o(err), .rd_en_i(rd_en), .rd_vld_o(rd_vld),
    .rd_data_o(rd_data), .rd_len_o(rd_len), .rd_last_o(rd_last)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  byte unsigned q0[$], q1[$];
  bit com0, com1, m_err, m_pend;
  int ws, rs, ptr, mps;

  function automatic int qsz(int s);
    return (s == 0) ? q0.size() : q1.size();
  endfunction
  function automatic int qat(int s, int i);
    return (s == 0) ? int'(q0[i]) : int'(q1[i]);
  endfunction
  function automatic bit comf(int s);
    return (s == 0) ? com0 : com1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0.delete(); q1.delete(); com0 = 0; com1 = 0; m_err = 0; m_pend = 0;
      ws = 0; rs = 0; ptr = 0; mps = MP;
    end else begin
      bit busy, cnow, wacc, pacc, racc, rlast;
      int len;
      busy  = (ptr != 0);
      cnow  = (clr || m_pend) && !busy;
      wacc  = wr_en && !comf(ws) && (qsz(ws) < mps);
      pacc  = pkt_en && !comf(ws);
      len   = qsz(rs);
      racc  = rd_en && comf(rs);
      rlast = (len == 0) || (ptr == len - 1);
      m_err = wr_en && !wacc;
      m_pend = (clr || m_pend) && busy;
      if (cnow) begin
        q0.delete(); q1.delete(); com0 = 0; com1 = 0; ws = 0; rs = 0; ptr = 0;
      end else begin
        if (wacc) begin
          if (ws == 0) q0.push_back(wr_data); else q1.push_back(wr_data);
        end
        if (pacc) begin
          if (ws == 0) com0 = 1; else com1 = 1;
          ws = 1 - ws;
        end
        if (racc) begin
          if (rlast) begin
            if (rs == 0) begin q0.delete(); com0 = 0; end
            else begin q1.delete(); com1 = 0; end
            rs = 1 - rs; ptr = 0;
          end else ptr++;
        end
      end
      if (cfg_we) mps = (int'(cfg_mps) > MP) ? MP : int'(cfg_mps);
    end
  end

  task automatic cmp();
    int len;
    bit v;
    v = comf(rs);
    len = qsz(rs);
    chk("R4 wr_rdy", wr_rdy, !(com0 && com1));
    chk("R5 rd_vld", rd_vld, v);
    if (v) begin
      chk("R5 rd_len", rd_len, len);
      chk("R5 rd_last", rd_last, (len == 0) || (ptr == len - 1));
      if (len > 0) chk("R2 rd_data", rd_data, qat(rs, ptr));
    end
    chk("R3 err", err, m_err);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp();
  endtask
  task automatic wr_byte(int b);
    wr_en = 1; wr_data = DW'(b); tick(); wr_en = 0;
  endtask
  task automatic commit();
    pkt_en = 1; tick(); pkt_en = 0;
  endtask
  task automatic rd_one();
    rd_en = 1; tick(); rd_en = 0;
  endtask
  task automatic drain();
    for (int k = 0; k < 300 && rd_vld; k++) rd_one();
  endtask
  task automatic set_mps(int v);
    cfg_we = 1; cfg_mps = CW'(v); tick(); cfg_we = 0;
  endtask
  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 wr_rdy", wr_rdy, 1);
    chk("R1 rd_vld", rd_vld, 0);
    chk("R1 err", err, 0);

    // R2 R4 R5: two packets, both committed, then overflow while full
    for (int i = 0; i < 5; i++) wr_byte(8'h10 + i);
    commit();
    for (int i = 0; i < 3; i++) wr_byte(8'h20 + i);
    commit();
    chk("R4 both committed", wr_rdy, 0);
    wr_byte(8'hee);
    chk("R3 err after drop", err, 1);
    commit();
    chk("R4 head len", rd_len, 5);
    drain();
    chk("R5 drained", rd_vld, 0);

    // R3 R8: reduced size cap
    set_mps(4);
    for (int i = 0; i < 6; i++) wr_byte(8'h30 + i);
    commit();
    chk("R3 capped len", rd_len, 4);
    drain();

    // R6 zero-length packet
    commit();
    chk("R6 vld", rd_vld, 1);
    chk("R6 len", rd_len, 0);
    chk("R6 last", rd_last, 1);
    rd_one();
    chk("R6 released", rd_vld, 0);

    // R9 write with trigger
    set_mps(MP);
    wr_byte(8'h41); wr_byte(8'h42);
    wr_en = 1; wr_data = 8'h43; pkt_en = 1; tick(); wr_en = 0; pkt_en = 0;
    chk("R9 len", rd_len, 3);
    drain();

    // R7 clear deferred mid-readout, then wipes both
    for (int i = 0; i < 4; i++) wr_byte(8'h50 + i);
    commit();
    wr_byte(8'h60); wr_byte(8'h61);
    commit();
    rd_one(); rd_one();
    clr = 1; tick(); clr = 0;
    chk("R7 deferred vld", rd_vld, 1);
    chk("R7 deferred len", rd_len, 4);
    rd_one(); rd_one();
    tick();
    chk("R7 cleared vld", rd_vld, 0);
    chk("R7 cleared rdy", wr_rdy, 1);

    // R7 idle clear
    wr_byte(8'h70); commit();
    clr = 1; tick(); clr = 0;
    chk("R7 idle clear", rd_vld, 0);

    // R8 clamp above maximum
    set_mps(100);
    for (int i = 0; i < MP + 2; i++) wr_byte(i);
    commit();
    chk("R8 clamped len", rd_len, MP);
    drain();

    // random mix
    for (int c = 0; c < 4000; c++) begin
      wr_en   = ($urandom % 3) != 0;
      wr_data = DW'($urandom);
      pkt_en  = ($urandom % 9) == 0;
      rd_en   = ($urandom % 2) == 0;
      clr     = ($urandom % 150) == 0;
      cfg_we  = ($urandom % 200) == 0;
      cfg_mps = CW'($urandom % 80);
      tick();
    end
    wr_en = 0; pkt_en = 0; rd_en = 0; clr = 0; cfg_we = 0;
    tick();
    finish_run();
  end
endmodule